// File: doc/BRIEF.md
# Steered Memory Chip-Select Decoder

This block turns every bus cycle of a 24-bit-address CPU into at most one active chip select. The targets are the CPU's own small SRAM, its mask ROM, the board SRAM, an expansion RAM, the on-board flash, a cartridge ROM, an expansion ROM, three fixed I/O windows (video, integrated peripherals, clock port) and a large window kept for user expansions. The decode is combinational. A cycle is qualified by `bus_en`, and `bus_we` tells reads from writes. A `cart_absent` input (high when no cartridge is fitted) picks between flash and cartridge ROM.

Three byte-wide control registers steer the decode. They sit on the same bus and are written by ordinary write cycles. The map register is at 0x00DF27, the boot register at 0x00DF40 and the speed register at 0x00DF41. When an enabled cycle selects nothing, `none_sel` is raised so that expansion hardware may claim the address. When a ROM is selected, `rom_ofs` carries the low 19 address bits. Low-memory ROM windows and their high-memory twins therefore land on the same flash bytes.

Top module: `mem_select_decoder`

## Requirements
- R1: After reset all three control registers hold zero. A read of 0x00E000 then selects mask ROM, 0x000000 selects the CPU SRAM, and 0x010000 selects nothing.
- R2: `chip_sel` has at most one bit set. When `bus_en` is low, all selects and `none_sel` are low. When `bus_en` is high, `none_sel` is high exactly when no select is active. Select bit order, from LSB: CPU SRAM, mask ROM, board SRAM, expansion RAM, flash, cartridge ROM, expansion ROM, video I/O, peripheral I/O, clock-port I/O, expansion window.
- R3: In 0x000000–0x0001FF, speed register bit 2 clear selects the CPU SRAM and bit 2 set selects the board SRAM.
- R4: In 0x000200–0x007FFF, the board SRAM is selected only when map bit 5 is set and map bit 3 is clear. Otherwise nothing is selected.
- R5: In 0x008000–0x00DEFF, map bit 4 set selects flash when `cart_absent` is high and cartridge ROM when it is low. With map bit 4 clear, nothing is selected.
- R6: 0x00DF00–0x00DF1F always selects video I/O, 0x00DF20–0x00DFBF selects peripheral I/O, and 0x00DFC0–0x00DFFF selects clock-port I/O.
- R7: In 0x00E000–0x00FFFF, boot bit 7 clear selects mask ROM. With boot bit 7 set, map bit 4 set selects flash, else map bit 5 set selects board SRAM, else nothing is selected.
- R8: Map bit 5 gates board SRAM at 0x010000–0x19FFFF and expansion RAM at 0x200000–0x3FFFFF. Map bit 6 gates the expansion window at 0x400000–0xBFFFFF. Map bit 7 gates flash at 0xC00000–0xC7FFFF and expansion ROM at 0xC80000–0xFFFFFF. 0x1A0000–0x1FFFFF never selects anything.
- R9: With map bits 5 and 4 both set, a write in 0x008000–0x00DEFF selects board SRAM. A write in 0x00E000–0x00FFFF also selects board SRAM when boot bit 7 is set. Reads in these cases still select ROM.
- R10: `rom_ofs` equals address bits 18:0 while mask ROM, flash, cartridge ROM or expansion ROM is selected, and is zero otherwise.
- R11: A control register takes `bus_wdata` at the clock edge of an enabled write to its exact address. Read cycles and writes to other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus cycle valid |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 24 | CPU address |
| bus_wdata | input | 8 | Write data for the control registers |
| cart_absent | input | 1 | High when no cartridge ROM is fitted |
| chip_sel | output | 11 | One-hot chip selects, bit order as in R2 |
| none_sel | output | 1 | Enabled cycle decoded to no device |
| rom_ofs | output | 19 | Offset into the selected ROM |

## Verification
The bench walks every region boundary: the first and last byte of each window, plus the unmapped gap above 0x19FFFF. An off-by-one limit would hand an edge byte to a neighbouring device or leave it unclaimed. It sets map bits 5 and 4 together and compares writes against reads in both split windows. A decoder that ignored the direction would let writes hit flash, and one that split unconditionally would send low-window writes to SRAM while boot bit 7 is clear. It checks the mirrored offsets of 0x008123/0xC08123 and 0x00E456/0xC0E456, which would differ if more than 19 bits passed through. It also checks that read cycles and writes to a neighbouring address leave the map register untouched.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 8;
    localparam int NUM_CS     = 11;
    localparam int NUM_REGION = 12;
    localparam int ROM_OFS_W  = 19;

    // chip-select bit positions
    localparam int CS_CPU_SRAM  = 0;
    localparam int CS_MASK_ROM  = 1;
    localparam int CS_BRD_SRAM  = 2;
    localparam int CS_EXP_RAM   = 3;
    localparam int CS_FLASH     = 4;
    localparam int CS_CART_ROM  = 5;
    localparam int CS_EXP_ROM   = 6;
    localparam int CS_VIDEO_IO  = 7;
    localparam int CS_PERIPH_IO = 8;
    localparam int CS_CLOCK_IO  = 9;
    localparam int CS_EXP_WIN   = 10;

    // region indices
    localparam int RG_LOWRAM = 0;
    localparam int RG_WORK   = 1;
    localparam int RG_ROMLO  = 2;
    localparam int RG_VIDEO  = 3;
    localparam int RG_PERIPH = 4;
    localparam int RG_CLOCK  = 5;
    localparam int RG_TOP    = 6;
    localparam int RG_BANKS  = 7;
    localparam int RG_XRAM   = 8;
    localparam int RG_XWIN   = 9;
    localparam int RG_FLASH  = 10;
    localparam int RG_XROM   = 11;

    localparam logic [ADDR_W-1:0] MAP_REG_ADDR   = 24'h00DF27;
    localparam logic [ADDR_W-1:0] BOOT_REG_ADDR  = 24'h00DF40;
    localparam logic [ADDR_W-1:0] SPEED_REG_ADDR = 24'h00DF41;

    typedef struct packed {
        logic [DATA_W-1:0] map;
        logic [DATA_W-1:0] boot;
        logic [DATA_W-1:0] speed;
    } ctl_regs_t;

    function automatic logic [ADDR_W-1:0] region_lo(input int idx);
        case (idx)
            0:       return 24'h000000;
            1:       return 24'h000200;
            2:       return 24'h008000;
            3:       return 24'h00DF00;
            4:       return 24'h00DF20;
            5:       return 24'h00DFC0;
            6:       return 24'h00E000;
            7:       return 24'h010000;
            8:       return 24'h200000;
            9:       return 24'h400000;
            10:      return 24'hC00000;
            default: return 24'hC80000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] region_hi(input int idx);
        case (idx)
            0:       return 24'h0001FF;
            1:       return 24'h007FFF;
            2:       return 24'h00DEFF;
            3:       return 24'h00DF1F;
            4:       return 24'h00DFBF;
            5:       return 24'h00DFFF;
            6:       return 24'h00FFFF;
            7:       return 24'h19FFFF;
            8:       return 24'h3FFFFF;
            9:       return 24'hBFFFFF;
            10:      return 24'hC7FFFF;
            default: return 24'hFFFFFF;
        endcase
    endfunction

endpackage

// File: rtl/mcs_ctl_regs.sv
module mcs_ctl_regs
    import mcs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output ctl_regs_t     regs
);

    ctl_regs_t regs_d, regs_q;
    logic      wr_cycle;

    always_comb begin
        wr_cycle = bus_en && bus_we;
        regs_d   = regs_q;
        if (wr_cycle && bus_addr == MAP_REG_ADDR)   regs_d.map   = bus_wdata;
        if (wr_cycle && bus_addr == BOOT_REG_ADDR)  regs_d.boot  = bus_wdata;
        if (wr_cycle && bus_addr == SPEED_REG_ADDR) regs_d.speed = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (regs_q == '0));

    assert_map_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == MAP_REG_ADDR) |=> (regs_q.map == $past(bus_wdata)));

    assert_hold_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we) |=> $stable(regs_q));

endmodule

// File: rtl/mcs_region_decode.sv
module mcs_region_decode
    import mcs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REGION
) (
    input  logic [AW-1:0] bus_addr,
    output logic [NR-1:0] hit
);

    for (genvar r = 0; r < NR; r++) begin : g_region
        assign hit[r] = (bus_addr >= region_lo(r)) && (bus_addr <= region_hi(r));
    end

    always_comb begin
        assert_region_disjoint_R2: assert ($onehot0(hit));
    end

endmodule

// File: rtl/mem_select_decoder.sv
module mem_select_decoder
    import mcs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = NUM_CS,
    parameter int OW = ROM_OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          cart_absent,
    output logic [CW-1:0] chip_sel,
    output logic          none_sel,
    output logic [OW-1:0] rom_ofs
);

    localparam int NR = NUM_REGION;
    localparam logic [CW-1:0] ROM_SET = (CW'(1) << CS_MASK_ROM) | (CW'(1) << CS_FLASH)
                                      | (CW'(1) << CS_CART_ROM) | (CW'(1) << CS_EXP_ROM);

    ctl_regs_t        regs;
    logic [NR-1:0]    hit;
    logic [CW-1:0]    sel;
    logic             m_lock, m_rom, m_ram, m_xwin, m_high, boot_ext, spd_brd;
    logic             split_wr;
    logic             unused_ctl_bits;

    mcs_ctl_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .regs      (regs)
    );

    mcs_region_decode #(.AW(AW), .NR(NR)) u_decode (
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    assign m_lock   = regs.map[3];
    assign m_rom    = regs.map[4];
    assign m_ram    = regs.map[5];
    assign m_xwin   = regs.map[6];
    assign m_high   = regs.map[7];
    assign boot_ext = regs.boot[7];
    assign spd_brd  = regs.speed[2];
    assign unused_ctl_bits = ^{regs.map[2:0], regs.boot[6:0], regs.speed[7:3], regs.speed[1:0]};

    always_comb begin
        sel      = '0;
        split_wr = m_rom && m_ram && bus_we;
        if (bus_en) begin
            if (hit[RG_LOWRAM])
                sel[spd_brd ? CS_BRD_SRAM : CS_CPU_SRAM] = 1'b1;
            if (hit[RG_WORK] && m_ram && !m_lock)
                sel[CS_BRD_SRAM] = 1'b1;
            if (hit[RG_ROMLO] && m_rom) begin
                if (split_wr)         sel[CS_BRD_SRAM] = 1'b1;
                else if (cart_absent) sel[CS_FLASH]    = 1'b1;
                else                  sel[CS_CART_ROM] = 1'b1;
            end
            if (hit[RG_VIDEO])  sel[CS_VIDEO_IO]  = 1'b1;
            if (hit[RG_PERIPH]) sel[CS_PERIPH_IO] = 1'b1;
            if (hit[RG_CLOCK])  sel[CS_CLOCK_IO]  = 1'b1;
            if (hit[RG_TOP]) begin
                if (!boot_ext)     sel[CS_MASK_ROM] = 1'b1;
                else if (m_rom)    sel[split_wr ? CS_BRD_SRAM : CS_FLASH] = 1'b1;
                else if (m_ram)    sel[CS_BRD_SRAM] = 1'b1;
            end
            if (hit[RG_BANKS] && m_ram)  sel[CS_BRD_SRAM] = 1'b1;
            if (hit[RG_XRAM]  && m_ram)  sel[CS_EXP_RAM]  = 1'b1;
            if (hit[RG_XWIN]  && m_xwin) sel[CS_EXP_WIN]  = 1'b1;
            if (hit[RG_FLASH] && m_high) sel[CS_FLASH]    = 1'b1;
            if (hit[RG_XROM]  && m_high) sel[CS_EXP_ROM]  = 1'b1;
        end
    end

    assign chip_sel = sel;
    assign none_sel = bus_en && (sel == '0);
    assign rom_ofs  = ((sel & ROM_SET) != '0) ? bus_addr[OW-1:0] : '0;

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_sel));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (chip_sel == '0 && !none_sel));

    assert_video_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_addr >= 24'h00DF00 && bus_addr <= 24'h00DF1F) |-> chip_sel[CS_VIDEO_IO]);

    assert_split_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && hit[RG_ROMLO] && regs.map[5:4] == 2'b11) |-> chip_sel[CS_BRD_SRAM]);

    assert_flash_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && chip_sel[CS_FLASH]) |-> (rom_ofs == bus_addr[OW-1:0]));

endmodule

// File: tb/tb_mem_select_decoder.sv
module tb_mem_select_decoder;

    localparam int CLK_PERIOD = 10;

    localparam logic [10:0] C_CPU  = 11'd1;
    localparam logic [10:0] C_MASK = 11'd2;
    localparam logic [10:0] C_BRD  = 11'd4;
    localparam logic [10:0] C_XRAM = 11'd8;
    localparam logic [10:0] C_FLSH = 11'd16;
    localparam logic [10:0] C_CART = 11'd32;
    localparam logic [10:0] C_XROM = 11'd64;
    localparam logic [10:0] C_VID  = 11'd128;
    localparam logic [10:0] C_PER  = 11'd256;
    localparam logic [10:0] C_CLK  = 11'd512;
    localparam logic [10:0] C_XWIN = 11'd1024;
    localparam logic [10:0] C_NONE = 11'd0;
    localparam logic [10:0] ROM_SET = C_MASK | C_FLSH | C_CART | C_XROM;

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  map;
        logic [7:0]  boot;
        logic [7:0]  speed;
        logic        cart;
        logic        we;
        logic [23:0] addr;
        logic [10:0] cs;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t TBL [NV] = '{
        '{8'd3,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h000010, C_CPU },  // R3
        '{8'd3,  8'h00, 8'h00, 8'h04, 1'b1, 1'b0, 24'h0001FF, C_BRD },  // R3
        '{8'd4,  8'h00, 8'h00, 8'h04, 1'b1, 1'b0, 24'h000200, C_NONE},  // R4
        '{8'd4,  8'h20, 8'h00, 8'h00, 1'b1, 1'b0, 24'h000200, C_BRD },  // R4
        '{8'd4,  8'h28, 8'h00, 8'h00, 1'b1, 1'b0, 24'h007FFF, C_NONE},  // R4
        '{8'd5,  8'h10, 8'h00, 8'h00, 1'b1, 1'b0, 24'h008000, C_FLSH},  // R5
        '{8'd5,  8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 24'h00DEFF, C_CART},  // R5
        '{8'd5,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h008000, C_NONE},  // R5
        '{8'd6,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h00DF00, C_VID },  // R6
        '{8'd6,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h00DF1F, C_VID },  // R6
        '{8'd6,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h00DF20, C_PER },  // R6
        '{8'd6,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h00DFBF, C_PER },  // R6
        '{8'd6,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h00DFC0, C_CLK },  // R6
        '{8'd6,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h00DFFF, C_CLK },  // R6
        '{8'd7,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h00E000, C_MASK},  // R7
        '{8'd7,  8'h10, 8'h80, 8'h00, 1'b1, 1'b0, 24'h00FFFF, C_FLSH},  // R7
        '{8'd7,  8'h20, 8'h80, 8'h00, 1'b1, 1'b0, 24'h00E000, C_BRD },  // R7
        '{8'd7,  8'h00, 8'h80, 8'h00, 1'b1, 1'b0, 24'h00E000, C_NONE},  // R7
        '{8'd9,  8'h30, 8'h80, 8'h00, 1'b1, 1'b1, 24'h00E000, C_BRD },  // R9
        '{8'd9,  8'h30, 8'h80, 8'h00, 1'b1, 1'b0, 24'h00E000, C_FLSH},  // R9
        '{8'd9,  8'h30, 8'h00, 8'h00, 1'b0, 1'b1, 24'h008000, C_BRD },  // R9
        '{8'd9,  8'h30, 8'h00, 8'h00, 1'b0, 1'b0, 24'h008000, C_CART},  // R9
        '{8'd8,  8'h20, 8'h00, 8'h00, 1'b1, 1'b0, 24'h010000, C_BRD },  // R8
        '{8'd8,  8'h20, 8'h00, 8'h00, 1'b1, 1'b0, 24'h19FFFF, C_BRD },  // R8
        '{8'd8,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h010000, C_NONE},  // R8
        '{8'd8,  8'hE0, 8'h00, 8'h00, 1'b1, 1'b0, 24'h1A0000, C_NONE},  // R8 gap
        '{8'd8,  8'h20, 8'h00, 8'h00, 1'b1, 1'b0, 24'h200000, C_XRAM},  // R8
        '{8'd8,  8'h20, 8'h00, 8'h00, 1'b1, 1'b0, 24'h3FFFFF, C_XRAM},  // R8
        '{8'd8,  8'h40, 8'h00, 8'h00, 1'b1, 1'b0, 24'h400000, C_XWIN},  // R8
        '{8'd8,  8'h40, 8'h00, 8'h00, 1'b1, 1'b0, 24'hBFFFFF, C_XWIN},  // R8
        '{8'd8,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'h400000, C_NONE},  // R8
        '{8'd8,  8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 24'hC00000, C_FLSH},  // R8
        '{8'd8,  8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 24'hC7FFFF, C_FLSH},  // R8
        '{8'd8,  8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 24'hC80000, C_XROM},  // R8
        '{8'd8,  8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 24'hFFFFFF, C_XROM},  // R8
        '{8'd8,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 24'hC80000, C_NONE},  // R8
        '{8'd9,  8'h30, 8'h00, 8'h00, 1'b1, 1'b1, 24'h00E000, C_MASK}   // R9 no split with boot bit 7 clear
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        cart_absent = 1'b1;
    logic [10:0] chip_sel;
    logic        none_sel;
    logic [18:0] rom_ofs;

    int n_checks = 0;
    int n_fail   = 0;

    mem_select_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cart_absent (cart_absent),
        .chip_sel    (chip_sel),
        .none_sel    (none_sel),
        .rom_ofs     (rom_ofs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (addr %06h)", req, what, got, exp, bus_addr);
        end
    endtask

    task automatic reg_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_regs(input logic [7:0] m, input logic [7:0] b, input logic [7:0] s);
        reg_write(24'h00DF27, m);
        reg_write(24'h00DF40, b);
        reg_write(24'h00DF41, s);
    endtask

    // drive one access at a negedge, sample 1 time unit later, release at the next negedge
    task automatic access(input string req, input logic [23:0] a, input logic we, input logic cart,
                          input logic [10:0] exp_cs, input logic [18:0] exp_ofs);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = a; cart_absent = cart; bus_wdata = 8'h00;
        #1;
        check(req, 32'(chip_sel), 32'(exp_cs), "chip_sel");
        check(req, 32'(none_sel), 32'(exp_cs == 11'd0), "none_sel");
        check(req, 32'(rom_ofs), 32'(exp_ofs), "rom_ofs");
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    function automatic logic [18:0] exp_offset(input logic [10:0] cs, input logic [23:0] a);
        return ((cs & ROM_SET) != 11'd0) ? a[18:0] : 19'd0;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        access("R1", 24'h00E000, 1'b0, 1'b1, C_MASK, 19'h0E000);
        access("R1", 24'h000000, 1'b0, 1'b1, C_CPU,  19'h0);
        access("R1", 24'h010000, 1'b0, 1'b1, C_NONE, 19'h0);

        // R2: disabled cycle drives nothing
        @(negedge clk);
        bus_en = 1'b0; bus_addr = 24'h00E000;
        #1;
        check("R2", 32'(chip_sel), 32'd0, "chip_sel idle");
        check("R2", 32'(none_sel), 32'd0, "none_sel idle");

        // table walk (R3..R9, R10 offsets)
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", TBL[i].req);
            set_regs(TBL[i].map, TBL[i].boot, TBL[i].speed);
            access(tag, TBL[i].addr, TBL[i].we, TBL[i].cart, TBL[i].cs,
                   exp_offset(TBL[i].cs, TBL[i].addr));
        end

        // R11: a read cycle at the map address and a write next to it change nothing
        set_regs(8'h00, 8'h00, 8'h00);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 24'h00DF27; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_en = 1'b0;
        access("R11", 24'hC00000, 1'b0, 1'b1, C_NONE, 19'h0);
        reg_write(24'h00DF26, 8'hFF);
        access("R11", 24'hC00000, 1'b0, 1'b1, C_NONE, 19'h0);
        reg_write(24'h00DF27, 8'h80);
        access("R11", 24'hC00000, 1'b0, 1'b1, C_FLSH, 19'h0);

        // R10: mirrored windows give equal offsets
        set_regs(8'h90, 8'h80, 8'h00);
        access("R10", 24'h008123, 1'b0, 1'b1, C_FLSH, 19'h08123);
        access("R10", 24'hC08123, 1'b0, 1'b1, C_FLSH, 19'h08123);
        access("R10", 24'h00E456, 1'b0, 1'b1, C_FLSH, 19'h0E456);
        access("R10", 24'hC0E456, 1'b0, 1'b1, C_FLSH, 19'h0E456);
        access("R10", 24'h00DF30, 1'b0, 1'b1, C_PER,  19'h0);

        // R1: reset in mid-run clears the map register
        set_regs(8'h20, 8'h80, 8'h04);
        access("R1", 24'h010000, 1'b0, 1'b1, C_BRD, 19'h0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access("R1", 24'h010000, 1'b0, 1'b1, C_NONE, 19'h0);
        access("R1", 24'h000100, 1'b0, 1'b1, C_CPU,  19'h0);
        access("R1", 24'h00E000, 1'b0, 1'b1, C_MASK, 19'h0E000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule